// File: doc/BRIEF.md
# Receive Address and Length Filter

This block sits on the receive path of an Ethernet MAC. It watches a byte-wide frame stream and, when each frame ends, decides whether the frame goes on to memory or is dropped. The decision rests on two tests:

- **Address test.** The destination address is checked against a programmed 48-bit station address. The upper/lower bit can optionally be left out of that compare. Broadcast and multicast destinations pass when they are enabled.
- **Length test.** The frame length is counted with the CRC included. Frames longer than 1518 bytes fail unless long-frame reception is allowed.

The flow is controlled by a three-state machine:

- **ST_IDLE**: no frame is open.
- **ST_DEST**: the six destination bytes are being collected.
- **ST_BODY**: the rest of the frame is arriving.

The transitions are:

- **START**: any state to ST_DEST when a byte is strobed with `rx_start`. This also restarts a frame that is already open.
- **DA_DONE**: ST_DEST to ST_BODY when the sixth destination byte is taken.
- **FRAME_END**: ST_DEST or ST_BODY to ST_IDLE when a byte is strobed with `rx_end`.
- **START_END**: straight back to ST_IDLE when a byte carries both `rx_start` and `rx_end`.

In the cycle after the last byte, the block raises `dec_valid` for exactly one cycle. In that cycle it also presents the accept/discard result and a match-type code.

Top module: `rx_addr_len_filter`

## Requirements
- R1: A byte is taken only when `rx_valid` is high. A taken byte that carries `rx_start` opens a new frame and abandons any frame already open. The taken byte that carries `rx_end` closes the frame. `dec_valid` is high for exactly the one cycle after the closing byte, and `dec_accept`/`dec_match` are 0 in all other cycles.
- R2: Destination byte k (k = 0 is received first) is compared with `cfg_ind_addr[8k+7:8k]`. Equality on all 48 bits is an individual match, reported as `dec_match` = 1 and accepted.
- R3: With `cfg_ignore_ul` = 1, bit 1 of destination byte 0 is left out of the individual compare. A frame that differs only in that bit is accepted with `dec_match` = 1, exactly like an exact match. With `cfg_ignore_ul` = 0, that difference causes a mismatch.
- R4: `cfg_ignore_ul` has no effect on broadcast or multicast classification.
- R5: A destination of all ones is a broadcast. It is accepted with `dec_match` = 3 only when `cfg_bcast_en` = 1.
- R6: A destination with bit 0 of byte 0 set that is not all ones is a multicast. It is accepted with `dec_match` = 2 only when `cfg_mcast_all` = 1.
- R7: A frame longer than 1518 bytes, counting the CRC, is discarded unless `cfg_long_ok` = 1. A frame of exactly 1518 bytes is not long. The match code is still reported for a frame discarded for length.
- R8: A frame that closes before six bytes have been taken is discarded with `dec_match` = 0.
- R9: The four configuration bits are sampled with the opening byte of a frame. Changing them later in the frame has no effect on that frame's decision.
- R10: The length counter saturates at its maximum value instead of wrapping, so a frame far longer than the counter range is still classed as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe for `rx_data` |
| rx_start | input | 1 | Marks the first byte of a frame |
| rx_end | input | 1 | Marks the last byte of a frame (CRC included) |
| rx_data | input | 8 | Received byte |
| cfg_ind_addr | input | 48 | Station address; bits [7:0] are the first byte on the wire |
| cfg_ignore_ul | input | 1 | Leave the upper/lower bit out of the station compare |
| cfg_long_ok | input | 1 | Allow frames longer than 1518 bytes |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_all | input | 1 | Accept all multicast |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | 1 = pass the frame to memory, 0 = discard |
| dec_match | output | 2 | 0 none, 1 individual, 2 multicast, 3 broadcast |

## Verification
The hardest condition to reach from the ports is saturation of the length counter. A counter that wraps only misbehaves once a frame exceeds the counter's full range. The bench therefore sends a 2100-byte frame: an 11-bit counter that wrapped would read 52 at that point and wrongly accept the frame. Two other conditions also need deliberate stimulus, because they only occur when inputs change while a frame is open. For configuration sampling, the bench changes the configuration bits right after the opening byte. For frame restart, it issues a second start strobe in the middle of an unfinished destination field.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEST = 2'd1,
        ST_BODY = 2'd2
    } rxf_state_e;

    typedef enum logic [1:0] {
        MT_NONE  = 2'd0,
        MT_IND   = 2'd1,
        MT_MCAST = 2'd2,
        MT_BCAST = 2'd3
    } rxf_match_e;

    localparam int unsigned DA_BYTES = 6;
    localparam int unsigned UL_BIT   = 1;
    localparam int unsigned GRP_BIT  = 0;
endpackage

// File: rtl/rxf_len_count.sv
module rxf_len_count #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    output logic [CNT_W-1:0] len_incl
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (restart)
            len_incl = CNT_W'(1);
        else if (cnt_q == {CNT_W{1'b1}})
            len_incl = cnt_q;
        else
            len_incl = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step)
            cnt_q <= len_incl;
    end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic        restart,
    input  logic [2:0]  idx,
    input  logic [7:0]  data,
    input  logic [47:0] ind_addr,
    input  logic        ignore_ul,
    output logic        ind_hit,
    output logic        all_ones,
    output logic        grp
);
    logic [DA_BYTES-1:0] byte_eq;
    logic ind_q, ones_q, grp_q;
    logic sel_eq;

    for (genvar g = 0; g < DA_BYTES; g++) begin : g_cmp
        logic [7:0] mask;
        assign mask = (g == 0 && ignore_ul) ? ~(8'd1 << UL_BIT) : 8'hFF;
        assign byte_eq[g] = (((data ^ ind_addr[8*g +: 8]) & mask) == 8'd0);
    end

    always_comb begin
        sel_eq = 1'b0;
        for (int i = 0; i < DA_BYTES; i++)
            if (idx == 3'(i)) sel_eq = byte_eq[i];
    end

    always_comb begin
        ind_hit  = ind_q;
        all_ones = ones_q;
        grp      = grp_q;
        if (step) begin
            ind_hit  = (restart ? 1'b1 : ind_q)  & sel_eq;
            all_ones = (restart ? 1'b1 : ones_q) & (data == 8'hFF);
            if (idx == 3'd0) grp = data[GRP_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ind_q  <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else begin
            ind_q  <= ind_hit;
            ones_q <= all_ones;
            grp_q  <= grp;
        end
    end
endmodule

// File: rtl/rx_addr_len_filter.sv
module rx_addr_len_filter
    import rxf_pkg::*;
#(
    parameter int unsigned MAX_LEN = 1518,
    parameter int unsigned CNT_W   = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_start,
    input  logic        rx_end,
    input  logic [7:0]  rx_data,
    input  logic [47:0] cfg_ind_addr,
    input  logic        cfg_ignore_ul,
    input  logic        cfg_long_ok,
    input  logic        cfg_bcast_en,
    input  logic        cfg_mcast_all,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic [1:0]  dec_match
);
    localparam logic [CNT_W-1:0] LEN_LIMIT = CNT_W'(MAX_LEN);
    localparam logic [2:0]       LAST_IDX  = 3'(DA_BYTES - 1);

    rxf_state_e state_q, state_d;
    logic [2:0] idx_q, idx_d, cur_idx;
    logic ign_q, lok_q, bc_q, mc_q;
    logic ign_e, lok_e, bc_e, mc_e;
    logic open_byte, in_frame, byte_in, da_step, last_byte, da_full, too_long;
    logic ind_hit, all_ones, grp;
    logic [CNT_W-1:0] len_incl;
    rxf_match_e match_d;

    assign open_byte = rx_valid && rx_start;
    assign in_frame  = open_byte || (state_q != ST_IDLE);
    assign byte_in   = rx_valid && in_frame;
    assign last_byte = byte_in && rx_end;
    assign cur_idx   = open_byte ? 3'd0 : idx_q;
    assign da_step   = byte_in && (open_byte || state_q == ST_DEST);
    assign da_full   = (!open_byte && state_q == ST_BODY) ||
                       (da_step && cur_idx == LAST_IDX);

    assign ign_e = open_byte ? cfg_ignore_ul : ign_q;
    assign lok_e = open_byte ? cfg_long_ok   : lok_q;
    assign bc_e  = open_byte ? cfg_bcast_en  : bc_q;
    assign mc_e  = open_byte ? cfg_mcast_all : mc_q;

    rxf_addr_match u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (da_step),
        .restart   (open_byte),
        .idx       (cur_idx),
        .data      (rx_data),
        .ind_addr  (cfg_ind_addr),
        .ignore_ul (ign_e),
        .ind_hit   (ind_hit),
        .all_ones  (all_ones),
        .grp       (grp)
    );

    rxf_len_count #(.CNT_W(CNT_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (byte_in),
        .restart  (open_byte),
        .len_incl (len_incl)
    );

    assign too_long = (len_incl > LEN_LIMIT);

    always_comb begin
        if (!da_full)                   match_d = MT_NONE;
        else if (all_ones && bc_e)      match_d = MT_BCAST;
        else if (grp && !all_ones && mc_e) match_d = MT_MCAST;
        else if (ind_hit)               match_d = MT_IND;
        else                            match_d = MT_NONE;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (open_byte) begin
            idx_d   = 3'd1;
            state_d = rx_end ? ST_IDLE : ST_DEST;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_DEST: begin
                    if (rx_end)                state_d = ST_IDLE;
                    else if (idx_q == LAST_IDX) state_d = ST_BODY;
                    else                       idx_d   = idx_q + 3'd1;
                end
                ST_BODY: if (rx_end) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and per-frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 3'd0;
            ign_q   <= 1'b0;
            lok_q   <= 1'b0;
            bc_q    <= 1'b0;
            mc_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (open_byte) begin
                ign_q <= cfg_ignore_ul;
                lok_q <= cfg_long_ok;
                bc_q  <= cfg_bcast_en;
                mc_q  <= cfg_mcast_all;
            end
        end
    end

    // decision outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_match  <= MT_NONE;
        end else begin
            dec_valid <= last_byte;
            if (last_byte) begin
                dec_accept <= (match_d != MT_NONE) && (!too_long || lok_e);
                dec_match  <= match_d;
            end else begin
                dec_accept <= 1'b0;
                dec_match  <= MT_NONE;
            end
        end
    end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int unsigned MAX_LEN = 1518,
    parameter int unsigned CNT_W   = 11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_start,
    input logic       rx_end,
    input logic       cfg_long_ok,
    input logic       dec_valid,
    input logic       dec_accept,
    input logic [1:0] dec_match
);
    localparam logic [CNT_W-1:0] LEN_LIMIT = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] MIN_DA    = CNT_W'(6);

    logic in_q, lok_q, sb, act, lok_e;
    logic [CNT_W-1:0] len_q, len_i;

    assign sb    = rx_valid && rx_start;
    assign act   = sb || in_q;
    assign lok_e = sb ? cfg_long_ok : lok_q;
    assign len_i = sb ? CNT_W'(1) :
                   (len_q == {CNT_W{1'b1}}) ? len_q : len_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= 1'b0;
            lok_q <= 1'b0;
            len_q <= '0;
        end else begin
            if (rx_valid && act) begin
                len_q <= len_i;
                in_q  <= !rx_end;
            end
            if (sb) lok_q <= cfg_long_ok;
        end
    end

    a_r1_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid && rx_end));

    a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_match == 2'd0));

    a_r2_accept_has_match: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> (dec_match != 2'd0));

    a_r7_long_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && act && rx_end && len_i > LEN_LIMIT && !lok_e)
        |=> (dec_valid && !dec_accept));

    a_r8_short_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && act && rx_end && len_i < MIN_DA)
        |=> (dec_valid && !dec_accept && dec_match == 2'd0));
endmodule

bind rx_addr_len_filter rxf_filter_chk #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_start    (rx_start),
    .rx_end      (rx_end),
    .cfg_long_ok (cfg_long_ok),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept),
    .dec_match   (dec_match)
);

// File: tb/rx_addr_len_filter_tb.sv
module rx_addr_len_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_start = 1'b0, rx_end = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [47:0] cfg_ind_addr = 48'h6655_4433_2210;
    logic        cfg_ignore_ul = 1'b0, cfg_long_ok = 1'b0;
    logic        cfg_bcast_en = 1'b0, cfg_mcast_all = 1'b0;
    logic        dec_valid, dec_accept;
    logic [1:0]  dec_match;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_addr_len_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_start(rx_start),
        .rx_end(rx_end), .rx_data(rx_data), .cfg_ind_addr(cfg_ind_addr),
        .cfg_ignore_ul(cfg_ignore_ul), .cfg_long_ok(cfg_long_ok),
        .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_all(cfg_mcast_all),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(dec_match)
    );

    localparam logic [47:0] IND  = 48'h6655_4433_2210;
    localparam logic [47:0] INDU = 48'h6655_4433_2212;
    localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC   = 48'h6655_4433_2211;
    localparam int NV = 17;
    // {dest, length, cfg{ign,lok,bc,mc}, exp_accept, exp_match}
    localparam logic [66:0] VECS [NV] = '{
        {IND,                 12'd64,   4'b0000, 1'b1, 2'd1},  // R2
        {48'h6755_4433_2210,  12'd64,   4'b0000, 1'b0, 2'd0},  // R2
        {INDU,                12'd64,   4'b0000, 1'b0, 2'd0},  // R3
        {INDU,                12'd64,   4'b1000, 1'b1, 2'd1},  // R3
        {IND,                 12'd64,   4'b1000, 1'b1, 2'd1},  // R3
        {BC,                  12'd64,   4'b0010, 1'b1, 2'd3},  // R5
        {BC,                  12'd64,   4'b0000, 1'b0, 2'd0},  // R5
        {MC,                  12'd64,   4'b0001, 1'b1, 2'd2},  // R6
        {MC,                  12'd64,   4'b0000, 1'b0, 2'd0},  // R6
        {48'hFFFF_FFFF_FFFD,  12'd64,   4'b1010, 1'b0, 2'd0},  // R4
        {BC,                  12'd64,   4'b1010, 1'b1, 2'd3},  // R4
        {IND,                 12'd1518, 4'b0000, 1'b1, 2'd1},  // R7
        {IND,                 12'd1519, 4'b0000, 1'b0, 2'd1},  // R7
        {IND,                 12'd1519, 4'b0100, 1'b1, 2'd1},  // R7
        {IND,                 12'd6,    4'b0000, 1'b1, 2'd1},  // R8
        {IND,                 12'd5,    4'b0000, 1'b0, 2'd0},  // R8
        {IND,                 12'd2100, 4'b0000, 1'b0, 2'd1}   // R10
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] c);
        cfg_ignore_ul = c[3];
        cfg_long_ok   = c[2];
        cfg_bcast_en  = c[1];
        cfg_mcast_all = c[0];
    endtask

    // drives one frame from a negedge; returns at the negedge where the decision is visible
    task automatic send_frame(input logic [47:0] dest, input int len,
                              input logic [3:0] cfg_a, input logic [3:0] cfg_b,
                              input int gap);
        set_cfg(cfg_a);
        for (int i = 0; i < len; i++) begin
            if (gap != 0 && i == gap) begin
                rx_valid = 1'b0; rx_start = 1'b0; rx_end = 1'b0; rx_data = 8'hAA;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_start = (i == 0);
            rx_end   = (i == len - 1);
            rx_data  = (i < 6) ? dest[8*i +: 8] : 8'(i);
            @(negedge clk);
            if (i == 0) set_cfg(cfg_b);
        end
        rx_valid = 1'b0; rx_start = 1'b0; rx_end = 1'b0;
    endtask

    task automatic expect_dec(input string req, input bit acc, input logic [1:0] code);
        check(dec_valid == 1'b1, req, int'(dec_valid), 1);
        check(dec_accept == acc, req, int'(dec_accept), int'(acc));
        check(dec_match == code, req, int'(dec_match), int'(code));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dec_valid == 1'b0 && dec_accept == 1'b0 && dec_match == 2'd0,
              "R1 reset", int'({dec_valid, dec_accept, dec_match}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            send_frame(VECS[v][66:19], int'(VECS[v][18:7]), VECS[v][6:3], VECS[v][6:3], 0);
            expect_dec($sformatf("vector %0d (R2..R10)", v), VECS[v][2], VECS[v][1:0]);
            @(negedge clk);
            // R1: the strobe lasts exactly one cycle
            check(dec_valid == 1'b0, "R1 one-cycle strobe", int'(dec_valid), 0);
        end

        // R10: long frame accepted when long-frame reception is on, even past counter range
        send_frame(IND, 2100, 4'b0100, 4'b0100, 0);
        expect_dec("R10 saturate long_ok", 1'b1, 2'd1);
        @(negedge clk);

        // R9: configuration changed after the opening byte has no effect
        send_frame(BC, 64, 4'b0010, 4'b0000, 0);
        expect_dec("R9 bcast kept", 1'b1, 2'd3);
        @(negedge clk);
        send_frame(BC, 64, 4'b0000, 4'b0010, 0);
        expect_dec("R9 bcast not enabled late", 1'b0, 2'd0);
        @(negedge clk);
        send_frame(INDU, 64, 4'b1000, 4'b0000, 0);
        expect_dec("R9 ignore_ul kept", 1'b1, 2'd1);
        @(negedge clk);
        send_frame(IND, 1600, 4'b0000, 4'b0100, 0);
        expect_dec("R9 long_ok not enabled late", 1'b0, 2'd1);
        @(negedge clk);

        // R1: idle bubble inside the destination field is skipped
        send_frame(IND, 64, 4'b0000, 4'b0000, 3);
        expect_dec("R1 bubble", 1'b1, 2'd1);
        @(negedge clk);

        // R1: a new start strobe abandons an unfinished frame
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_start = (i == 0); rx_end = 1'b0; rx_data = 8'hFF;
            @(negedge clk);
        end
        check(dec_valid == 1'b0, "R1 no decision mid-frame", int'(dec_valid), 0);
        send_frame(IND, 64, 4'b0000, 4'b0000, 0);
        expect_dec("R1 restart", 1'b1, 2'd1);
        @(negedge clk);

        // R1: end strobe outside a frame is ignored
        rx_valid = 1'b1; rx_end = 1'b1; rx_data = 8'h10;
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b0;
        check(dec_valid == 1'b0, "R1 stray end", int'(dec_valid), 0);

        // R8: single-byte frame
        send_frame(IND, 1, 4'b0010, 4'b0010, 0);
        expect_dec("R8 one byte", 1'b0, 2'd0);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule